// File: doc/BRIEF.md
# Fetch-Stage Branch Predictor with Target Buffer and History Counters

This block sits beside instruction fetch and guesses, for every fetch address, whether a conditional branch lives there, where it goes, and whether it will be taken. A set-associative target buffer keeps, per entry, a tag, the branch destination and four 2-bit saturating counters. A 2-bit global history of the last two resolved conditional branches picks which of the four counters speaks for the entry. When the branch resolves later in the pipeline, the resolution port trains the selected counter or allocates a new entry, and shifts the outcome into the history.

Branches that miss the buffer but are found by the decoder get a static guess on a separate path: a backward displacement is guessed taken and a forward one not taken. A hit predicted taken raises a bubble flag, because redirecting fetch costs one cycle; a hit predicted not taken costs nothing and raises no flag. Unconditional jumps are never placed in the buffer.

Top module: `btb_predictor`

## Requirements
- R1: A synchronous active-high reset clears every entry's valid bit, the global history (to 2'b00) and all registered outputs, so the first lookups after reset miss.
- R2: A lookup presented with `fetch_valid` high yields its result two clock edges later. A hit needs a valid entry in the indexed set whose tag equals the upper PC bits; on a miss, `pred_hit`, `pred_taken`, `pred_bubble` are 0 and `pred_target` is 0.
- R3: The set index is PC bits [10:4] and the tag is PC bits [31:11]; a hit returns the destination written by the most recent resolution of that branch.
- R4: On a hit, `pred_taken` equals bit 1 of the counter whose number (0 to 3) equals the current history value.
- R5: Counters are 2-bit saturating (00 strongly not taken up to 11 strongly taken). A resolution that hits moves only the counter chosen by the current history, one step toward the outcome. An allocation sets all four counters to 2'b10 and then moves the chosen one in the same way.
- R6: Each resolved conditional branch shifts the history left with the outcome entering bit 0 (1 taken, 0 not taken); nothing else changes it.
- R7: A resolution with `res_cond` low (unconditional jump) allocates nothing, trains nothing and leaves the history unchanged.
- R8: `pred_bubble` is high exactly when a lookup hits and predicts taken.
- R9: `miss_taken` is registered one cycle after `miss_valid` and equals `miss_backward` for a valid request, 0 otherwise.
- R10: A missing conditional resolution allocates into the lowest-numbered invalid way of its set; with all four valid it replaces the tree pseudo-LRU victim (root bit picks ways 0-1 when 0 or 2-3 when 1, the pair bit picks the lower way when 0). Every allocation or training hit marks its way most recently used.
- R11: When a lookup and a resolution arrive in the same cycle, the lookup result already reflects that resolution.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_valid | input | 1 | Lookup request |
| fetch_pc | input | PC_W | Fetch address to predict |
| res_valid | input | 1 | Resolved branch present |
| res_pc | input | PC_W | Address of the resolved branch |
| res_target | input | PC_W | Resolved destination |
| res_taken | input | 1 | Resolved outcome, 1 taken |
| res_cond | input | 1 | 1 for conditional branch, 0 for unconditional jump |
| miss_valid | input | 1 | Decoded branch that missed the buffer |
| miss_backward | input | 1 | Displacement sign of that branch, 1 backward |
| pred_hit | output | 1 | Lookup found an entry |
| pred_target | output | PC_W | Predicted destination, 0 on a miss |
| pred_taken | output | 1 | Predicted direction |
| pred_bubble | output | 1 | Taken hit, fetch loses one cycle |
| miss_taken | output | 1 | Static direction for a missing branch |

## Verification
The history assertions take for granted that the resolution inputs stay low while reset is high, so the shift check never compares against a cycle that was being reset; the bench holds every input at zero until reset is released. The static-path and miss-output checks assume the request strobes are single-cycle pulses driven between clock edges, which is how every bench task drives them. Stimulus reaches each set only through addresses whose index and tag fields are chosen on purpose, so a hit or miss always has one intended cause.

// File: rtl/btbp_pkg.sv
package btbp_pkg;
  // The replacement tree below is written for exactly four ways.
  localparam int unsigned WAYS   = 4;
  localparam int unsigned WAY_W  = 2;
  localparam int unsigned HIST_W = 2;
  localparam int unsigned NCTR   = 1 << HIST_W;

  typedef logic [1:0] ctr_t;
  localparam ctr_t CTR_INIT = 2'b10;

  function automatic ctr_t ctr_step(ctr_t c, logic tk);
    ctr_t r;
    r = c;
    if (tk && c != 2'b11) r = c + 2'd1;
    else if (!tk && c != 2'b00) r = c - 2'd1;
    return r;
  endfunction

  // tree bit 0: root, bit 1: ways 0/1, bit 2: ways 2/3
  function automatic logic [WAY_W-1:0] plru_victim(logic [2:0] t);
    if (!t[0]) return {1'b0, t[1]};
    return {1'b1, t[2]};
  endfunction

  function automatic logic [2:0] plru_touch(logic [2:0] t, logic [WAY_W-1:0] w);
    logic [2:0] r;
    r = t;
    r[0] = ~w[1];
    if (!w[1]) r[1] = ~w[0];
    else r[2] = ~w[0];
    return r;
  endfunction
endpackage

// File: rtl/btbp_way.sv
module btbp_way #(
  parameter int unsigned SET_W = 7,
  parameter int unsigned TAG_W = 21,
  parameter int unsigned TGT_W = 32,
  parameter int unsigned NCTR  = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [SET_W-1:0]       a_idx,
  output logic                   a_vld,
  output logic [TAG_W-1:0]       a_tag,
  output logic [TGT_W-1:0]       a_tgt,
  output logic [NCTR-1:0][1:0]   a_ctr,
  input  logic [SET_W-1:0]       b_idx,
  output logic                   b_vld,
  output logic [TAG_W-1:0]       b_tag,
  output logic [NCTR-1:0][1:0]   b_ctr,
  input  logic                   we,
  input  logic [SET_W-1:0]       w_idx,
  input  logic [TAG_W-1:0]       w_tag,
  input  logic [TGT_W-1:0]       w_tgt,
  input  logic [NCTR-1:0][1:0]   w_ctr
);
  localparam int unsigned SETS = 1 << SET_W;

  logic [SETS-1:0]     vld_q;
  logic [TAG_W-1:0]    tag_mem [SETS];
  logic [TGT_W-1:0]    tgt_mem [SETS];
  logic [NCTR-1:0][1:0] ctr_mem [SETS];

  always_ff @(posedge clk) begin
    if (rst) vld_q <= '0;
    else if (we) vld_q[w_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (we) begin
      tag_mem[w_idx] <= w_tag;
      tgt_mem[w_idx] <= w_tgt;
      ctr_mem[w_idx] <= w_ctr;
    end
  end

  assign a_vld = vld_q[a_idx];
  assign a_tag = tag_mem[a_idx];
  assign a_tgt = tgt_mem[a_idx];
  assign a_ctr = ctr_mem[a_idx];
  assign b_vld = vld_q[b_idx];
  assign b_tag = tag_mem[b_idx];
  assign b_ctr = ctr_mem[b_idx];

  // R1
  valid_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (vld_q == '0));
endmodule

// File: rtl/btbp_plru.sv
module btbp_plru #(
  parameter int unsigned SET_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SET_W-1:0] rd_idx,
  output logic [1:0]       victim,
  input  logic             touch,
  input  logic [SET_W-1:0] touch_idx,
  input  logic [1:0]       touch_way
);
  import btbp_pkg::*;
  localparam int unsigned SETS = 1 << SET_W;

  logic [2:0] tree_q [SETS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) tree_q[s] <= 3'b000;
    end else if (touch) begin
      tree_q[touch_idx] <= plru_touch(tree_q[touch_idx], touch_way);
    end
  end

  assign victim = plru_victim(tree_q[rd_idx]);
endmodule

// File: rtl/btbp_ghr.sv
module btbp_ghr #(
  parameter int unsigned HIST_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              taken,
  output logic [HIST_W-1:0] hist
);
  always_ff @(posedge clk) begin
    if (rst) hist <= '0;
    else if (en) hist <= {hist[HIST_W-2:0], taken};
  end

  // R6
  ghr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(en)) |-> $stable(hist));
  // R6
  ghr_shift_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(en)) |-> (hist[0] == $past(taken)) && (hist[1] == $past(hist[0])));
endmodule

// File: rtl/btb_predictor.sv
module btb_predictor #(
  parameter int unsigned PC_W    = 32,
  parameter int unsigned IDX_LSB = 4,
  parameter int unsigned SET_W   = 7
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            fetch_valid,
  input  logic [PC_W-1:0] fetch_pc,
  input  logic            res_valid,
  input  logic [PC_W-1:0] res_pc,
  input  logic [PC_W-1:0] res_target,
  input  logic            res_taken,
  input  logic            res_cond,
  input  logic            miss_valid,
  input  logic            miss_backward,
  output logic            pred_hit,
  output logic [PC_W-1:0] pred_target,
  output logic            pred_taken,
  output logic            pred_bubble,
  output logic            miss_taken
);
  import btbp_pkg::*;
  localparam int unsigned TAG_W = PC_W - IDX_LSB - SET_W;

  // lookup stage 1 registers
  logic            lk_v_q;
  logic [PC_W-1:0] lk_pc_q;

  logic [SET_W-1:0] lk_idx, up_idx;
  logic [TAG_W-1:0] lk_tag, up_tag;
  assign lk_idx = lk_pc_q[IDX_LSB +: SET_W];
  assign lk_tag = lk_pc_q[PC_W-1 -: TAG_W];
  assign up_idx = res_pc[IDX_LSB +: SET_W];
  assign up_tag = res_pc[PC_W-1 -: TAG_W];

  logic [WAYS-1:0]      a_vld, b_vld, way_we;
  logic [TAG_W-1:0]     a_tag [WAYS];
  logic [TAG_W-1:0]     b_tag [WAYS];
  logic [PC_W-1:0]      a_tgt [WAYS];
  logic [NCTR-1:0][1:0] a_ctr [WAYS];
  logic [NCTR-1:0][1:0] b_ctr [WAYS];
  logic [NCTR-1:0][1:0] new_ctr;
  logic [HIST_W-1:0]    hist;
  logic [WAY_W-1:0]     victim;

  logic upd_go;
  assign upd_go = res_valid && res_cond;

  generate
    for (genvar g = 0; g < WAYS; g++) begin : g_way
      btbp_way #(.SET_W(SET_W), .TAG_W(TAG_W), .TGT_W(PC_W), .NCTR(NCTR)) u_way (
        .clk(clk), .rst(rst),
        .a_idx(lk_idx), .a_vld(a_vld[g]), .a_tag(a_tag[g]), .a_tgt(a_tgt[g]), .a_ctr(a_ctr[g]),
        .b_idx(up_idx), .b_vld(b_vld[g]), .b_tag(b_tag[g]), .b_ctr(b_ctr[g]),
        .we(way_we[g]), .w_idx(up_idx), .w_tag(up_tag), .w_tgt(res_target), .w_ctr(new_ctr)
      );
    end
  endgenerate

  // lookup match
  logic                 a_hit;
  logic [PC_W-1:0]      a_sel_tgt;
  logic [NCTR-1:0][1:0] a_sel_ctr;
  logic                 a_pred;
  always_comb begin
    a_hit = 1'b0;
    a_sel_tgt = '0;
    a_sel_ctr = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (a_vld[w] && a_tag[w] == lk_tag) begin
        a_hit = 1'b1;
        a_sel_tgt = a_tgt[w];
        a_sel_ctr = a_ctr[w];
      end
    end
    a_pred = a_sel_ctr[hist][1];
  end

  // resolution match, way choice and counter training
  logic                 b_hit, fill_found;
  logic [WAY_W-1:0]     b_way, fill_way, tgt_way;
  logic [NCTR-1:0][1:0] b_sel_ctr, base_ctr;
  always_comb begin
    b_hit = 1'b0;
    b_way = '0;
    b_sel_ctr = '0;
    fill_way = victim;
    fill_found = 1'b0;
    for (int w = 0; w < WAYS; w++) begin
      if (b_vld[w] && b_tag[w] == up_tag) begin
        b_hit = 1'b1;
        b_way = WAY_W'(w);
        b_sel_ctr = b_ctr[w];
      end
      if (!b_vld[w] && !fill_found) begin
        fill_way = WAY_W'(w);
        fill_found = 1'b1;
      end
    end
    tgt_way = b_hit ? b_way : fill_way;
    base_ctr = b_hit ? b_sel_ctr : {NCTR{CTR_INIT}};
    new_ctr = base_ctr;
    new_ctr[hist] = ctr_step(base_ctr[hist], res_taken);
    for (int w = 0; w < WAYS; w++) way_we[w] = upd_go && (tgt_way == WAY_W'(w));
  end

  btbp_plru #(.SET_W(SET_W)) u_plru (
    .clk(clk), .rst(rst), .rd_idx(up_idx), .victim(victim),
    .touch(upd_go), .touch_idx(up_idx), .touch_way(tgt_way)
  );

  btbp_ghr #(.HIST_W(HIST_W)) u_ghr (
    .clk(clk), .rst(rst), .en(upd_go), .taken(res_taken), .hist(hist)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      lk_v_q      <= 1'b0;
      lk_pc_q     <= '0;
      pred_hit    <= 1'b0;
      pred_target <= '0;
      pred_taken  <= 1'b0;
      pred_bubble <= 1'b0;
      miss_taken  <= 1'b0;
    end else begin
      lk_v_q      <= fetch_valid;
      lk_pc_q     <= fetch_pc;
      pred_hit    <= lk_v_q && a_hit;
      pred_target <= (lk_v_q && a_hit) ? a_sel_tgt : '0;
      pred_taken  <= lk_v_q && a_hit && a_pred;
      pred_bubble <= lk_v_q && a_hit && a_pred;
      miss_taken  <= miss_valid && miss_backward;
    end
  end

  // R2
  miss_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !pred_hit |-> (pred_target == '0) && !pred_taken);
  // R8
  bubble_taken_chk: assert property (@(posedge clk) disable iff (rst)
    pred_bubble |-> (pred_hit && pred_taken));
  // R10
  write_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(way_we));
  // R7
  uncond_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_cond) |-> (way_we == '0));
  // R9
  miss_dir_chk: assert property (@(posedge clk) disable iff (rst)
    miss_taken |-> $past(miss_valid && miss_backward));
endmodule

// File: tb/sim_btb_predictor.sv
module sim_btb_predictor;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        fetch_valid = 1'b0;
  logic [31:0] fetch_pc = '0;
  logic        res_valid = 1'b0;
  logic [31:0] res_pc = '0;
  logic [31:0] res_target = '0;
  logic        res_taken = 1'b0;
  logic        res_cond = 1'b0;
  logic        miss_valid = 1'b0;
  logic        miss_backward = 1'b0;
  logic        pred_hit, pred_taken, pred_bubble, miss_taken;
  logic [31:0] pred_target;

  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  btb_predictor u0 (
    .clk(clk), .rst(rst), .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
    .res_valid(res_valid), .res_pc(res_pc), .res_target(res_target),
    .res_taken(res_taken), .res_cond(res_cond), .miss_valid(miss_valid),
    .miss_backward(miss_backward), .pred_hit(pred_hit), .pred_target(pred_target),
    .pred_taken(pred_taken), .pred_bubble(pred_bubble), .miss_taken(miss_taken)
  );

  typedef struct packed {
    logic        is_upd;
    logic [31:0] pc;
    logic [31:0] tgt;
    logic        tk;
    logic        cond;
    logic        e_hit;
    logic        e_tk;
    logic [31:0] e_tgt;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 17;
  localparam logic [31:0] PA = 32'h0000_1040;
  localparam logic [31:0] PB = 32'h0000_3050;
  localparam vec_t VECS [NV] = '{
    '{1'b0, PA, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0,    4'd2}, // R2 cold miss
    '{1'b1, PA, 32'h2000, 1'b1, 1'b1, 1'b0, 1'b0, 32'h0, 4'd5}, // alloc, hist 00->01
    '{1'b0, PA, 32'h0, 1'b0, 1'b0, 1'b1, 1'b1, 32'h2000, 4'd4}, // R4 ctr1=10
    '{1'b1, PA, 32'h2000, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0, 4'd5}, // ctr1->01, hist 10
    '{1'b0, PA, 32'h0, 1'b0, 1'b0, 1'b1, 1'b1, 32'h2000, 4'd6}, // R6 ctr2=10
    '{1'b1, PA, 32'h2000, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0, 4'd5}, // ctr2->01, hist 00
    '{1'b0, PA, 32'h0, 1'b0, 1'b0, 1'b1, 1'b1, 32'h2000, 4'd4}, // R4 ctr0=11
    '{1'b1, PB, 32'h4000, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0, 4'd7}, // unconditional jump
    '{1'b0, PB, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0,    4'd7}, // R7 not allocated
    '{1'b0, PA, 32'h0, 1'b0, 1'b0, 1'b1, 1'b1, 32'h2000, 4'd7}, // R7 hist still 00
    '{1'b1, PA, 32'h2000, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0, 4'd5}, // ctr0 10
    '{1'b1, PA, 32'h2000, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0, 4'd5}, // ctr0 01
    '{1'b1, PA, 32'h2000, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0, 4'd5}, // ctr0 00
    '{1'b1, PA, 32'h2000, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0, 4'd5}, // ctr0 stays 00
    '{1'b0, PA, 32'h0, 1'b0, 1'b0, 1'b1, 1'b0, 32'h2000, 4'd5}, // R5 saturated low
    '{1'b1, PA, 32'h2400, 1'b1, 1'b1, 1'b0, 1'b0, 32'h0, 4'd3}, // new target, hist 01
    '{1'b0, PA, 32'h0, 1'b0, 1'b0, 1'b1, 1'b0, 32'h2400, 4'd3}  // R3 refreshed target
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_lookup(input logic [31:0] pc);
    @(negedge clk);
    fetch_valid = 1'b1;
    fetch_pc = pc;
    @(negedge clk);
    fetch_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic do_update(input logic [31:0] pc, input logic [31:0] tgt, input logic tk, input logic cond);
    @(negedge clk);
    res_valid = 1'b1;
    res_pc = pc;
    res_target = tgt;
    res_taken = tk;
    res_cond = cond;
    @(negedge clk);
    res_valid = 1'b0;
    res_cond = 1'b0;
  endtask

  task automatic expect_look(input string req, input logic h, input logic tk, input logic [31:0] tg);
    chk(pred_hit == h, req, 32'(pred_hit), 32'(h));
    chk(pred_taken == tk, req, 32'(pred_taken), 32'(tk));
    chk(pred_bubble == (h && tk), {req, " bubble R8"}, 32'(pred_bubble), 32'(h && tk));
    chk(pred_target == tg, req, pred_target, tg);
  endtask

  function automatic logic [31:0] set16(input int t);
    return (32'(t) << 11) | 32'h100;
  endfunction

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state of outputs
    chk(pred_hit == 1'b0 && pred_taken == 1'b0 && pred_bubble == 1'b0, "R1", 32'(pred_hit), 32'h0);
    chk(pred_target == 32'h0 && miss_taken == 1'b0, "R1", pred_target, 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].is_upd) begin
        do_update(VECS[i].pc, VECS[i].tgt, VECS[i].tk, VECS[i].cond);
      end else begin
        do_lookup(VECS[i].pc);
        expect_look($sformatf("R%0d vec%0d", VECS[i].req, i), VECS[i].e_hit, VECS[i].e_tk, VECS[i].e_tgt);
      end
    end

    // R9 static direction for buffer misses
    @(negedge clk); miss_valid = 1'b1; miss_backward = 1'b1;
    @(negedge clk); miss_valid = 1'b0;
    chk(miss_taken == 1'b1, "R9 backward", 32'(miss_taken), 32'h1);
    miss_backward = 1'b0; miss_valid = 1'b1;
    @(negedge clk); miss_valid = 1'b0;
    chk(miss_taken == 1'b0, "R9 forward", 32'(miss_taken), 32'h0);
    miss_backward = 1'b1;
    @(negedge clk); miss_backward = 1'b0;
    chk(miss_taken == 1'b0, "R9 no request", 32'(miss_taken), 32'h0);

    // R10 fill ways 0..3 of set 0x10, then two replacements
    for (int t = 8; t < 12; t++) do_update(set16(t), set16(t) + 32'h100, 1'b1, 1'b1);
    for (int t = 8; t < 12; t++) begin
      do_lookup(set16(t));
      expect_look("R10 fill", 1'b1, 1'b1, set16(t) + 32'h100);
    end
    do_update(set16(12), set16(12) + 32'h100, 1'b1, 1'b1);
    do_lookup(set16(8));
    expect_look("R10 way0 evicted", 1'b0, 1'b0, 32'h0);
    do_lookup(set16(12));
    expect_look("R10 new entry", 1'b1, 1'b1, set16(12) + 32'h100);
    do_update(set16(13), set16(13) + 32'h100, 1'b1, 1'b1);
    do_lookup(set16(10));
    expect_look("R10 way2 evicted", 1'b0, 1'b0, 32'h0);
    do_lookup(set16(9));
    expect_look("R10 way1 kept", 1'b1, 1'b1, set16(9) + 32'h100);

    // R11 lookup and resolution of the same branch in one cycle
    @(negedge clk);
    fetch_valid = 1'b1; fetch_pc = 32'h0000_0A00;
    res_valid = 1'b1; res_pc = 32'h0000_0A00; res_target = 32'h0000_5550;
    res_taken = 1'b1; res_cond = 1'b1;
    @(negedge clk);
    fetch_valid = 1'b0; res_valid = 1'b0; res_cond = 1'b0;
    @(negedge clk);
    chk(pred_hit == 1'b1, "R11 hit", 32'(pred_hit), 32'h1);
    chk(pred_target == 32'h0000_5550, "R11 target", pred_target, 32'h0000_5550);

    // R1 reset mid-run empties the buffer
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    do_lookup(PA);
    expect_look("R1 after reset", 1'b0, 1'b0, 32'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule